// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects a clocked request port to an external 32K x 8 asynchronous static RAM. The RAM has active-low chip, output and write strobes and one bidirectional 8-bit data bus. A user presents a request with a direction flag, a word address and write data while `ready` is high. The controller then runs one complete RAM cycle, reports completion with a one-clock `done` pulse, and, for a read, leaves the fetched byte on `rdata`.

The RAM's nanosecond limits are turned into clock counts at elaboration time from a clock-period parameter given in picoseconds. Each count is the limit divided by the period, rounded up, and never less than one. The controller drives the data bus only while its write strobe is low. After every read it keeps the chip deselected long enough for the RAM's output drivers to let go of the bus. Between accesses the chip is deselected. A standby request parks the chip deselected so that its supply may be lowered. When the request is withdrawn, the controller waits one read-cycle time before it accepts more work.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1, `done` and `stby_ok` are 0, `rdata` is 0 and the controller is idle.
- R2: A read (`req`=1, `wr`=0, accepted while `ready`=1) holds `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for RD=ceil(max(70 ns, 70 ns)/period) cycles (9 at 8 ns). During those cycles `sram_addr` holds the requested address. The bus is sampled on the last of these cycles.
- R3: A write (`req`=1, `wr`=1) pulls `sram_ce_n` and `sram_we_n` low on the same edge. `sram_we_n` stays low for WE=ceil(max(50, 60, 40 ns)/period) cycles (8), with `sram_oe_n`=1, `sram_addr` held and `sram_dq` driven with the write data.
- R4: After the write strobe rises, `sram_ce_n` stays low for max(1, ceil(70 ns/period)-WE) cycles (1) with the bus released. The controller drives `sram_dq` only while `sram_ce_n`=0, `sram_we_n`=0 and `sram_oe_n`=1.
- R5: After a read, all strobes are high for HZ=ceil(30 ns/period) cycles (4) before `ready` returns, so no write can drive the bus while the RAM's outputs are still turning off.
- R6: `done` is high for exactly one clock per completed request. For a read, it is high in the first cycle after the access window, with `rdata` already updated. For a write, it is high in the first idle cycle. `rdata` keeps its value until the next read completes.
- R7: `ready` is high only when the controller is idle and no standby is requested. A `req` seen while `ready` is low starts nothing and leaves the ongoing cycle unchanged.
- R8: While idle, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are all 1.
- R9: `sleep_req`=1 seen while idle puts the controller in standby. In standby `stby_ok`=1, `ready`=0, all strobes are 1, and requests are ignored.
- R10: When `sleep_req` falls in standby, the controller keeps all strobes high and `ready` low for ceil(70 ns/period) cycles (9) before returning to idle.
- R11: If `sleep_req` and `req` are both high in the same idle cycle, standby is entered and the request is not started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period given by `CLK_PS` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an access when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address of the request |
| wdata | input | DW | Byte to write |
| sleep_req | input | 1 | Ask for standby / retention |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Byte captured by the last read |
| stby_ok | output | 1 | Chip parked deselected; supply may be lowered |
| sram_addr | output | AW | RAM address bus |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq | inout | DW | Shared RAM data bus |

## Verification
Isolated reads and writes at the lowest and highest addresses, with all-zero and all-one data, fix the length of each strobe window. They also show that each byte lands where it was sent. Holding `req` high across many completions forces read-after-read, write-after-read and read-after-write sequences, which separate a correct turnaround gap from one that is missing or too short. Raising standby together with a request, during a busy read, and then withdrawing it, tells the sleep priority and the wake delay apart from ordinary idle behaviour. Requests that toggle while the controller is busy or asleep show whether any of them leaks into a RAM cycle.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int CLK_PS  = 8000,
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_WC_NS = 70,
  parameter int T_WP_NS = 50,
  parameter int T_CW_NS = 60,
  parameter int T_DS_NS = 40,
  parameter int T_HZ_NS = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          sleep_req,
  output logic          ready,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          stby_ok,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  inout  wire  [DW-1:0] sram_dq
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ns2cyc(int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_CYC = ns2cyc(imax(T_RC_NS, T_AA_NS));
  localparam int WE_CYC = ns2cyc(imax(T_WP_NS, imax(T_CW_NS, T_DS_NS)));
  localparam int WT_CYC = imax(1, ns2cyc(T_WC_NS) - WE_CYC);
  localparam int HZ_CYC = ns2cyc(T_HZ_NS);
  localparam int WK_CYC = ns2cyc(T_RC_NS);
  localparam int CW     = $clog2(imax(imax(RD_CYC, WE_CYC), imax(HZ_CYC, WK_CYC)) + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_TURN, S_WRITE, S_WREC, S_SLEEP, S_WAKE
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          dq_oe;
  logic [DW-1:0] dq_out;

  assign sram_dq = dq_oe ? dq_out : 'z;
  assign ready   = (state == S_IDLE) && !sleep_req;
  assign stby_ok = (state == S_SLEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sram_addr <= '0;
      sram_ce_n <= 1'b1;
      sram_oe_n <= 1'b1;
      sram_we_n <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (sleep_req) begin
            state <= S_SLEEP;
          end else if (req) begin
            sram_addr <= addr;
            sram_ce_n <= 1'b0;
            if (wr) begin
              sram_we_n <= 1'b0;
              dq_oe     <= 1'b1;
              dq_out    <= wdata;
              cnt       <= CW'(WE_CYC - 1);
              state     <= S_WRITE;
            end else begin
              sram_oe_n <= 1'b0;
              cnt       <= CW'(RD_CYC - 1);
              state     <= S_READ;
            end
          end
        end
        S_READ: begin
          if (cnt == '0) begin
            rdata     <= sram_dq;
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            done      <= 1'b1;
            cnt       <= CW'(HZ_CYC - 1);
            state     <= S_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TURN: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        S_WRITE: begin
          if (cnt == '0) begin
            sram_we_n <= 1'b1;
            dq_oe     <= 1'b0;
            cnt       <= CW'(WT_CYC - 1);
            state     <= S_WREC;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WREC: begin
          if (cnt == '0) begin
            sram_ce_n <= 1'b1;
            done      <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_SLEEP: begin
          if (!sleep_req) begin
            cnt   <= CW'(WK_CYC - 1);
            state <= S_WAKE;
          end
        end
        S_WAKE: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int AW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          done,
  input logic          stby_ok,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_oe_n,
  input logic          sram_we_n,
  input logic          dq_oe,
  input int            hz_cyc,
  input int            we_cyc
);
  int oe_gap;
  int we_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_gap <= 1000;
      we_len <= 0;
    end else begin
      oe_gap <= !sram_oe_n ? 0 : ((oe_gap < 1000) ? oe_gap + 1 : oe_gap);
      we_len <= !sram_we_n ? we_len + 1 : 0;
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (sram_oe_n && !sram_we_n && !sram_ce_n)); // R4
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (oe_gap >= hz_cyc)); // R5
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_len >= we_cyc)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sram_ce_n && sram_oe_n && sram_we_n)); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr)); // R2
  AST_STANDBY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    stby_ok |-> (sram_ce_n && !ready)); // R9
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .done      (done),
  .stby_ok   (stby_ok),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_oe_n (sram_oe_n),
  .sram_we_n (sram_we_n),
  .dq_oe     (dq_oe),
  .hz_cyc    (HZ_CYC),
  .we_cyc    (WE_CYC)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int PER_PS = 8000;
  localparam int RD_N = (70000 + PER_PS - 1) / PER_PS;
  localparam int WE_N = (60000 + PER_PS - 1) / PER_PS;
  localparam int WT_N = ((70000 + PER_PS - 1) / PER_PS) - WE_N;
  localparam int HZ_N = (30000 + PER_PS - 1) / PER_PS;
  localparam int WK_N = (70000 + PER_PS - 1) / PER_PS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic          sleep_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  wire           ready, done, stby_ok, ce_n, oe_n, we_n;
  wire  [DW-1:0] rdata;
  wire  [AW-1:0] sram_addr;
  wire  [DW-1:0] dq;

  always #4 clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .sleep_req(sleep_req), .ready(ready), .done(done), .rdata(rdata),
    .stby_ok(stby_ok), .sram_addr(sram_addr), .sram_ce_n(ce_n),
    .sram_oe_n(oe_n), .sram_we_n(we_n), .sram_dq(dq)
  );

  function automatic logic [7:0] fill(int a);
    return 8'(a ^ (a >> 7)) ^ 8'h5A;
  endfunction

  logic [7:0] sram_mem [int];
  logic [7:0] rd_val;
  logic [7:0] wlatch;
  always_comb rd_val = sram_mem.exists(int'(sram_addr)) ? sram_mem[int'(sram_addr)] : fill(int'(sram_addr));
  assign dq = (!ce_n && !oe_n && we_n) ? rd_val : 'z;
  always @(negedge clk) if (!ce_n && !we_n) wlatch = dq;
  always @(posedge we_n) if (!ce_n) sram_mem[int'(sram_addr)] = wlatch;

  typedef struct {
    bit ce, oe, we, drv, dyn, dn, sb, chka;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string tag;
  } rec_t;

  rec_t          q[$];
  rec_t          cur;
  bit            sleeping = 1'b0;
  bit            last_idle = 1'b1;
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] exp_rdata = '0;
  int            vectors = 0;
  int            errors = 0;

  function automatic rec_t mk(bit ce, bit oe, bit we, bit drv, bit dyn, bit dn, bit sb,
                              bit chka, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    rec_t r;
    r.ce = ce; r.oe = oe; r.we = we; r.drv = drv; r.dyn = dyn; r.dn = dn;
    r.sb = sb; r.chka = chka; r.a = a; r.d = d; r.tag = tag;
    return r;
  endfunction

  task automatic push_read(logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(int'(a));
    repeat (RD_N) q.push_back(mk(0, 0, 1, 0, 0, 0, 0, 1, a, '0, "R2"));
    q.push_back(mk(1, 1, 1, 0, 0, 1, 0, 0, a, v, "R6"));
    repeat (HZ_N - 1) q.push_back(mk(1, 1, 1, 0, 0, 0, 0, 0, a, '0, "R5"));
  endtask

  task automatic push_write(logic [AW-1:0] a, logic [DW-1:0] d);
    ref_mem[int'(a)] = d;
    repeat (WE_N) q.push_back(mk(0, 1, 0, 1, 0, 0, 0, 1, a, d, "R3"));
    repeat (WT_N) q.push_back(mk(0, 1, 1, 0, 0, 0, 0, 1, a, d, "R4"));
    q.push_back(mk(1, 1, 1, 0, 1, 1, 0, 0, a, d, "R6"));
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    string tag;
    bit    entered_sleep;
    bit    busy_req;
    @(negedge clk);
    entered_sleep = 1'b0;
    busy_req = 1'b0;
    if (q.size() == 0) begin
      if (sleeping) begin
        if (!sleep_req) begin
          sleeping = 1'b0;
          repeat (WK_N) q.push_back(mk(1, 1, 1, 0, 0, 0, 0, 0, '0, '0, "R10"));
        end else if (req) begin
          busy_req = 1'b1;
        end
      end else if (last_idle) begin
        if (sleep_req) begin
          sleeping = 1'b1;
          entered_sleep = req;
        end else if (req) begin
          if (wr) push_write(addr, wdata);
          else    push_read(addr);
        end
      end else if (req) begin
        busy_req = 1'b1;
      end
    end else if (req) begin
      busy_req = 1'b1;
    end

    if (q.size() != 0)  cur = q.pop_front();
    else if (sleeping)  cur = mk(1, 1, 1, 0, 0, 0, 1, 0, '0, '0, "R9");
    else                cur = mk(1, 1, 1, 0, 1, 0, 0, 0, '0, '0, "R8");
    last_idle = cur.dyn;

    tag = cur.tag;
    if (entered_sleep) tag = "R11";
    else if (busy_req) tag = {cur.tag, "/R7"};
    if (cur.dn && !cur.dyn) exp_rdata = cur.d;

    vectors++;
    chk(ce_n == cur.ce, tag, "ce_n", int'(ce_n), int'(cur.ce));
    chk(oe_n == cur.oe, tag, "oe_n", int'(oe_n), int'(cur.oe));
    chk(we_n == cur.we, tag, "we_n", int'(we_n), int'(cur.we));
    chk(ready == (cur.dyn && !sleep_req), {tag, "/R7"}, "ready", int'(ready), int'(cur.dyn && !sleep_req));
    chk(done == cur.dn, tag, "done", int'(done), int'(cur.dn));
    chk(stby_ok == cur.sb, tag, "stby_ok", int'(stby_ok), int'(cur.sb));
    if (cur.chka) chk(sram_addr == cur.a, tag, "sram_addr", int'(sram_addr), int'(cur.a));
    if (cur.drv)  chk(dq == cur.d, tag, "sram_dq", int'(dq), int'(cur.d));
    chk(rdata == exp_rdata, "R6", "rdata", int'(rdata), int'(exp_rdata));
  endtask

  task automatic run(int n);
    repeat (n) step();
  endtask

  task automatic drive(bit r, bit w, logic [AW-1:0] a, logic [DW-1:0] d, bit s);
    req = r; wr = w; addr = a; wdata = d; sleep_req = s;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      vectors++;
      chk(ce_n && oe_n && we_n, "R1", "strobes", int'({ce_n, oe_n, we_n}), 7);
      chk(!done && !stby_ok, "R1", "done/stby_ok", int'({done, stby_ok}), 0);
      chk(rdata == '0, "R1", "rdata", int'(rdata), 0);
    end
    rst_n = 1'b1;
    run(3);

    drive(1, 1, 15'h0000, 8'h3C, 0); run(1); drive(0, 0, '0, '0, 0); run(12);
    drive(1, 0, 15'h0000, 8'h00, 0); run(1); drive(0, 0, '0, '0, 0); run(16);
    drive(1, 0, 15'h7FFF, 8'h00, 0); run(1); drive(0, 0, '0, '0, 0); run(16);
    drive(1, 1, 15'h7FFF, 8'hFF, 0); run(1);
    drive(1, 0, 15'h7FFF, 8'h00, 0); run(40);
    drive(1, 1, 15'h0001, 8'h81, 0); run(3);
    drive(1, 0, 15'h0001, 8'h00, 0); run(14);
    drive(1, 1, 15'h0000, 8'h00, 0); run(11);
    drive(1, 0, 15'h0000, 8'h00, 0); run(1); drive(0, 0, '0, '0, 0); run(16);

    drive(1, 0, 15'h1234, 8'h00, 1); run(2);
    for (int i = 0; i < 6; i++) begin
      drive(i[0], i[1], 15'h2000, 8'h77, 1); run(1);
    end
    drive(1, 0, 15'h0001, 8'h00, 0); run(14);
    drive(0, 0, '0, '0, 0); run(20);

    drive(1, 0, 15'h7FFF, 8'h00, 0); run(1);
    drive(0, 0, '0, '0, 1); run(20);
    drive(1, 1, 15'h4321, 8'hA5, 0); run(1);
    drive(1, 0, 15'h4321, 8'h00, 0); run(30);
    drive(0, 0, '0, '0, 0); run(20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1..) actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule